// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver with Nesting

This block decides which of a set of interrupt request levels (eight by default) is presented to the processor. Each cycle it looks at the request, mask and in-service vectors kept by the surrounding controller, together with a pointer to the current lowest-priority level and a special-mask flag. Priority runs in a circle. The level one step above the pointer ranks first, and rank falls as the scan moves forward and wraps around.

When no interrupt is pending and an eligible request exists, the block raises its interrupt output on the next clock edge and latches the chosen level. Both stay put until the processor acknowledges. The block also finds the in-service bit that a non-specific end-of-interrupt must clear. It does this with the same circular order and returns a one-hot clear vector to the owner of the in-service register.

Edge capture of the request lines and formation of the vector are handled elsewhere.

Top module: `rot_prio_resolver`

## Requirements
- R1: After reset, `int_out` is 0, `level_out` is 0, and `eoi_clr` is 0 while `eoi_req` is low.
- R2: The highest-ranked level is (`low_ptr` + 1) mod NUM_LV. Rank then falls level by level in increasing index with wrap-around, so with `low_ptr` = 7, level 0 ranks first and level 7 ranks last.
- R3: Level i is a candidate only when `req_vec[i]` is 1 and `mask_vec[i]` is 0. The chosen level is the highest-ranked eligible candidate.
- R4: While `int_out` is 1, no new level is selected and `level_out` holds its value, whatever the requests do.
- R5: `ack` high at a clock edge drives `int_out` to 0 at that edge. This overrides any selection in the same cycle.
- R6: With `spec_mask` = 0, the scan stops at the first level (in rank order) whose `svc_vec` bit is 1. Only strictly higher-ranked candidates may be chosen. If the top-ranked level is in service, nothing is raised.
- R7: With `spec_mask` = 1, every level is scanned and any level whose `svc_vec` bit is 1 is skipped.
- R8: `eoi_clr` is one-hot with its bit at the first level in rank order whose `svc_vec` bit is 1, while `eoi_req` is 1. It is all zero when `eoi_req` is 0 or `svc_vec` is 0.
- R9: A decision takes one clock. If `int_out` is 0, `ack` is 0 and an eligible candidate exists in a cycle, then `int_out` is 1 and `level_out` holds that candidate right after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vec | input | NUM_LV | Request vector |
| mask_vec | input | NUM_LV | Mask vector, 1 = level masked |
| svc_vec | input | NUM_LV | In-service vector |
| low_ptr | input | LW | Lowest-priority level pointer |
| spec_mask | input | 1 | Special mask mode enable |
| ack | input | 1 | Processor acknowledge of the pending interrupt |
| eoi_req | input | 1 | Non-specific end-of-interrupt request |
| int_out | output | 1 | Interrupt pending toward the processor |
| level_out | output | LW | Latched level of the pending interrupt |
| eoi_clr | output | NUM_LV | One-hot in-service bit to clear on EOI |

## Verification
The bench puts the pointer near the wrap point and checks that a request at a numerically low level outranks a higher index. A design that scanned linearly would pick the wrong level there.

It puts an in-service bit between two requests, so that a design without nesting would raise the lower request. It also sets the top-ranked level in service, where a correct design stays silent. Special mask mode is exercised with the only request sitting on an in-service level; a design that ignored the skip would raise it.

Requests also change while an interrupt is pending, and `ack` collides with a fresh candidate. A design that re-arbitrated during pending would drift `level_out`, and one that ignored the precedence of `ack` would keep `int_out` high.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  // modular addition used for every rotate / un-rotate step
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b,
                                           int unsigned n);
    return (a + b) % n;
  endfunction
endpackage

// File: rtl/rpr_rotate.sv
module rpr_rotate #(
  parameter int N  = 8,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [N-1:0]  dout
);
  // dout[i] is the level that ranks i-th when din[amt] ranks first
  for (genvar i = 0; i < N; i++) begin : g_rot
    assign dout[i] = din[SW'(rpr_pkg::wrap_add(i, int'(amt), N))];
  end
endmodule

// File: rtl/rpr_first_set.sv
module rpr_first_set #(
  parameter int N  = 8,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [SW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = SW'(i);
    end
  end
  assign found = |vec;
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
  parameter int NUM_LV = 8,
  parameter int LW     = $clog2(NUM_LV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_LV-1:0] req_vec,
  input  logic [NUM_LV-1:0] mask_vec,
  input  logic [NUM_LV-1:0] svc_vec,
  input  logic [LW-1:0]     low_ptr,
  input  logic              spec_mask,
  input  logic              ack,
  input  logic              eoi_req,
  output logic              int_out,
  output logic [LW-1:0]     level_out,
  output logic [NUM_LV-1:0] eoi_clr
);
  localparam logic [NUM_LV-1:0] ONE_V = NUM_LV'(1);

  logic [LW-1:0]     hp_w;       // top-ranked level
  logic [NUM_LV-1:0] cand_w;     // unmasked requests
  logic [NUM_LV-1:0] cand_r, svc_r, allow_r, elig_r;
  logic              svc_found, pick_found;
  logic [LW-1:0]     svc_idx, pick_idx;
  logic [LW-1:0]     sel_lvl, eoi_lvl;
  logic              raise_w;    // selection event this cycle

  assign hp_w   = LW'(rpr_pkg::wrap_add(int'(low_ptr), 1, NUM_LV));
  assign cand_w = req_vec & ~mask_vec;

  rpr_rotate #(.N(NUM_LV), .SW(LW)) u_rot_cand (
    .din(cand_w), .amt(hp_w), .dout(cand_r));
  rpr_rotate #(.N(NUM_LV), .SW(LW)) u_rot_svc (
    .din(svc_vec), .amt(hp_w), .dout(svc_r));

  rpr_first_set #(.N(NUM_LV), .SW(LW)) u_fs_svc (
    .vec(svc_r), .found(svc_found), .idx(svc_idx));

  // rank positions open to arbitration
  always_comb begin
    if (spec_mask)       allow_r = ~svc_r;
    else if (!svc_found) allow_r = '1;
    else                 allow_r = (ONE_V << svc_idx) - ONE_V;
  end
  assign elig_r = cand_r & allow_r;

  rpr_first_set #(.N(NUM_LV), .SW(LW)) u_fs_pick (
    .vec(elig_r), .found(pick_found), .idx(pick_idx));

  assign sel_lvl = LW'(rpr_pkg::wrap_add(int'(pick_idx), int'(hp_w), NUM_LV));
  assign eoi_lvl = LW'(rpr_pkg::wrap_add(int'(svc_idx), int'(hp_w), NUM_LV));
  assign eoi_clr = (eoi_req && svc_found) ? (ONE_V << eoi_lvl) : '0;

  assign raise_w = !int_out && !ack && pick_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_out   <= 1'b0;
      level_out <= '0;
    end else if (ack) begin
      int_out   <= 1'b0;
    end else if (raise_w) begin
      int_out   <= 1'b1;
      level_out <= sel_lvl;
    end
  end

  // R4
  hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_out && $past(int_out)) |-> $stable(level_out));
  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !int_out);
  // R3
  pick_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_out) |-> ((($past(cand_w) >> level_out) & ONE_V) != '0));
  // R7
  skip_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_out) && $past(spec_mask)) |->
      ((($past(svc_vec) >> level_out) & ONE_V) == '0));
  // R6
  top_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_out && !spec_mask && svc_vec[hp_w]) |=> !int_out);
  // R8
  eoi_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eoi_clr) && ((eoi_clr & ~svc_vec) == '0));
endmodule

// File: tb/rot_prio_resolver_bench.sv
module rot_prio_resolver_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_vec = '0, mask_vec = '0, svc_vec = '0;
  logic [2:0]   low_ptr = 3'd7;
  logic spec_mask = 1'b0, ack = 1'b0, eoi_req = 1'b0;
  logic int_out;
  logic [2:0] level_out;
  logic [N-1:0] eoi_clr;

  int n_cmp = 0, n_bad = 0;
  int exp_int = 0, exp_lvl = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;   // 50 MHz

  rot_prio_resolver u_rot_prio_resolver (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec),
    .svc_vec(svc_vec), .low_ptr(low_ptr), .spec_mask(spec_mask), .ack(ack),
    .eoi_req(eoi_req), .int_out(int_out), .level_out(level_out),
    .eoi_clr(eoi_clr));

  // walk ranks from the top; returns -1 if nothing qualifies
  function automatic int ref_pick(logic [N-1:0] rq, logic [N-1:0] mk,
                                  logic [N-1:0] sv, int ptr, logic sm);
    int top = (ptr + 1) % N;
    for (int k = 0; k < N; k++) begin
      int l = (top + k) % N;
      if (sv[l]) begin
        if (!sm) return -1;
      end else if (rq[l] && !mk[l]) return l;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] ref_eoi(logic [N-1:0] sv, int ptr, logic er);
    int top = (ptr + 1) % N;
    logic [N-1:0] r = '0;
    if (er) begin
      for (int k = N - 1; k >= 0; k--)
        if (sv[(top + k) % N]) r = '0 | (N'(1) << ((top + k) % N));
    end
    return r;
  endfunction

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic [N-1:0] rq, logic [N-1:0] mk, logic [N-1:0] sv,
                     logic [2:0] ptr, logic sm, logic ak, logic er);
    int p;
    @(negedge clk);
    cmp("int_out", int'(int_out), exp_int);
    if (exp_int != 0) cmp("level_out", int'(level_out), exp_lvl);
    req_vec = rq; mask_vec = mk; svc_vec = sv; low_ptr = ptr;
    spec_mask = sm; ack = ak; eoi_req = er;
    #1;
    cmp("eoi_clr", int'(eoi_clr), int'(ref_eoi(sv, int'(ptr), er)));
    p = ref_pick(rq, mk, sv, int'(ptr), sm);
    if (ak) exp_int = 0;
    else if (exp_int == 0 && p >= 0) begin exp_int = 1; exp_lvl = p; end
  endtask

  initial begin
    #5000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    cmp("int_out", int'(int_out), 0);
    cmp("level_out", int'(level_out), 0);
    cmp("eoi_clr", int'(eoi_clr), 0);
    rst_n = 1'b1;
    cyc('0, '0, '0, 3'd7, 0, 0, 0);

    cur_tag = "R2";  // ptr 7: level 0 beats 7; ptr 3: level 4 beats 3
    cyc(8'h81, '0, '0, 3'd7, 0, 0, 0);
    cyc(8'h00, '0, '0, 3'd7, 0, 1, 0);
    cyc(8'h19, '0, '0, 3'd3, 0, 0, 0);
    cyc(8'h00, '0, '0, 3'd3, 0, 1, 0);

    cur_tag = "R3";  // mask hides level 0; all masked raises nothing
    cyc(8'h03, 8'h01, '0, 3'd7, 0, 0, 0);
    cyc(8'h00, '0, '0, 3'd7, 0, 1, 0);
    cyc(8'hF0, 8'hF0, '0, 3'd7, 0, 0, 0);
    cyc(8'hF0, 8'hF0, '0, 3'd7, 0, 0, 0);

    cur_tag = "R4";  // higher request arrives while pending
    cyc(8'h20, '0, '0, 3'd7, 0, 0, 0);
    cyc(8'h21, '0, '0, 3'd7, 0, 0, 0);
    cyc(8'h01, '0, '0, 3'd7, 0, 0, 0);

    cur_tag = "R5";  // ack with candidate present, then re-raise
    cyc(8'h01, '0, '0, 3'd7, 0, 1, 0);
    cyc(8'h01, '0, '0, 3'd7, 0, 0, 0);
    cyc(8'h00, '0, '0, 3'd7, 0, 1, 0);

    cur_tag = "R6";  // nesting blocks lower, top in service blocks all
    cyc(8'h0A, '0, 8'h04, 3'd7, 0, 0, 0);
    cyc(8'h00, '0, 8'h04, 3'd7, 0, 1, 0);
    cyc(8'h08, '0, 8'h04, 3'd7, 0, 0, 0);
    cyc(8'h02, '0, 8'h01, 3'd7, 0, 0, 0);
    cyc(8'h02, '0, 8'h01, 3'd7, 0, 0, 0);

    cur_tag = "R7";  // special mask: skip in-service level only
    cyc(8'h03, '0, 8'h01, 3'd7, 1, 0, 0);
    cyc(8'h00, '0, 8'h01, 3'd7, 1, 1, 0);
    cyc(8'h01, '0, 8'h01, 3'd7, 1, 0, 0);
    cyc(8'h01, '0, 8'h01, 3'd7, 1, 0, 0);

    cur_tag = "R8";  // EOI clear order and gating
    cyc(8'h00, '0, 8'h90, 3'd5, 0, 0, 1);
    cyc(8'h00, '0, 8'h90, 3'd7, 0, 0, 1);
    cyc(8'h00, '0, 8'h90, 3'd7, 0, 0, 0);
    cyc(8'h00, '0, 8'h00, 3'd7, 0, 0, 1);

    cur_tag = "R9";  // random mix, one-cycle decision every cycle
    for (int i = 0; i < 400; i++)
      cyc(N'($urandom), N'($urandom) & N'($urandom), N'($urandom) & N'($urandom),
          3'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
          ($urandom % 2) == 0);
    cyc('0, '0, '0, 3'd7, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule